// File: doc/BRIEF.md
# Scrambled Arithmetic Stand-in for a Multiply/Divide Unit

This block takes the place of a CPU's fixed-point multiply, divide and modulo unit when the rest of the core is proven by a bounded model check. A true multiplier or divider makes such proofs blow up. Each operation is therefore replaced by a single 64-bit add or subtract, followed by an XOR with a constant chosen per operation. The control logic around the unit still sees a distinct and data-dependent value for every opcode. Every operand bit still reaches the result, so a wrong operand routing or a wrong opcode cannot cancel out.

The unit accepts one operation per cycle under `in_valid`. It returns two values one cycle later, together with `out_valid`. The first is the value to be written to the destination register (`out_rt`). The second is the unscrambled sum or difference (`out_r`). The condition flags are taken from `out_r` as a signed number, never from the scrambled write value. This mirrors the rule that record-form and overflow side effects use the internal result.

Top module: `alt_muldiv_sub`

## Requirements
- R1: While `rst_n` is low and after reset, until the first accepted operation, `out_valid`, `out_rt`, `out_r`, `out_lt`, `out_gt` and `out_eq` are all 0.
- R2: `out_valid` is 1 in the cycle after each clock edge that samples `in_valid` high, and 0 after each edge that samples it low.
- R3: Opcode 0 (multiply-low-immediate): r = RA + sign-extended 16-bit `in_imm`, and RT = r XOR 0xEF31A883837039A0.
- R4: Opcodes 1 (multiply-low-word) and 2 (multiply-high-word): r = sign-extended RA[31:0] + sign-extended RB[31:0]. The masks are 0x4931591F31F56DE1 for opcode 1 and 0x3426DCF55920989C for opcode 2.
- R5: Opcode 3 (unsigned multiply-high-word): r = zero-extended RA[31:0] + zero-extended RB[31:0], with mask 0x491EDB8A5F695D49.
- R6: Opcodes 4 (divide-word) and 6 (divide-word-extended): r = sign-extended RA[31:0] − sign-extended RB[31:0]. The masks are 0x75A5D4895A3E15BA for opcode 4 and 0xDFD9D577965D84D2 for opcode 6.
- R7: Opcodes 5 (unsigned divide-word) and 7 (unsigned divide-word-extended): r = zero-extended RA[31:0] − zero-extended RB[31:0]. The masks are 0x769C76AF68D11402 for opcode 5 and 0x8FC71F88B966FCF0 for opcode 7.
- R8: Opcode 8 (signed modulo-word) uses the sign-extended difference with mask 0x5BA1758B11AE4E43. Opcode 9 (unsigned modulo-word) uses the zero-extended difference with mask 0x1FEB9D95F9F0CEA5.
- R9: The flags come from r read as a signed 64-bit value: `out_lt` = r<0, `out_gt` = r>0, `out_eq` = r==0. Exactly one of the three is 1 whenever `out_valid` is 1.
- R10: Opcodes 10 to 15 are unassigned. They give r = 0 and RT = 0, so `out_eq` = 1.
- R11: In a cycle with `in_valid` low, `out_rt`, `out_r` and the flags keep their previous values, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation select (encoding in R3 to R10) |
| in_ra | input | 64 | First register operand |
| in_rb | input | 64 | Second register operand |
| in_imm | input | 16 | Signed immediate operand |
| out_valid | output | 1 | Result present this cycle |
| out_rt | output | 64 | Scrambled value for the destination register |
| out_r | output | 64 | Unscrambled internal result |
| out_lt | output | 1 | Internal result negative |
| out_gt | output | 1 | Internal result positive |
| out_eq | output | 1 | Internal result zero |

## Verification
On every cycle, the assertions check several relations:
- the one-cycle valid latency;
- the one-hot flag set, and that `out_eq` matches a zero result;
- that `out_rt` XOR `out_r` equals the mask of the opcode accepted one cycle earlier;
- that outputs hold when no operation arrives;
- that unassigned opcodes give zero.

The XOR check ties every opcode to its own constant, but it cannot show that the operands were extended and combined correctly. The bench's scenarios provide that coverage with directed and random operations. The directed cases include low words with the sign bit set, junk in the upper halves, equal operands and negative immediates.

// File: rtl/altmd_pkg.sv
package altmd_pkg;

  localparam int MASK_W = 64;

  typedef enum logic [3:0] {
    OPC_MULI   = 4'd0,
    OPC_MULLW  = 4'd1,
    OPC_MULHW  = 4'd2,
    OPC_MULHWU = 4'd3,
    OPC_DIVW   = 4'd4,
    OPC_DIVWU  = 4'd5,
    OPC_DIVWE  = 4'd6,
    OPC_DIVWEU = 4'd7,
    OPC_MODSW  = 4'd8,
    OPC_MODUW  = 4'd9
  } altop_e;

  // Control decoded from an opcode
  typedef struct packed {
    logic known;       // opcode is assigned
    logic use_imm;     // second operand is the immediate, first is the full RA
    logic word_signed; // low words are sign-extended (else zero-extended)
    logic subtract;    // difference instead of sum
  } opctl_t;

  function automatic opctl_t decode_op(input logic [3:0] code);
    opctl_t c;
    c = '0;
    case (code)
      OPC_MULI:   c = '{known: 1'b1, use_imm: 1'b1, word_signed: 1'b1, subtract: 1'b0};
      OPC_MULLW,
      OPC_MULHW:  c = '{known: 1'b1, use_imm: 1'b0, word_signed: 1'b1, subtract: 1'b0};
      OPC_MULHWU: c = '{known: 1'b1, use_imm: 1'b0, word_signed: 1'b0, subtract: 1'b0};
      OPC_DIVW,
      OPC_DIVWE,
      OPC_MODSW:  c = '{known: 1'b1, use_imm: 1'b0, word_signed: 1'b1, subtract: 1'b1};
      OPC_DIVWU,
      OPC_DIVWEU,
      OPC_MODUW:  c = '{known: 1'b1, use_imm: 1'b0, word_signed: 1'b0, subtract: 1'b1};
      default:    c = '0;
    endcase
    return c;
  endfunction

  // Per-opcode XOR constant; unassigned codes scramble nothing
  function automatic logic [MASK_W-1:0] scramble_mask(input logic [3:0] code);
    logic [MASK_W-1:0] m;
    case (code)
      OPC_MULI:   m = 64'hEF31_A883_8370_39A0;
      OPC_MULLW:  m = 64'h4931_591F_31F5_6DE1;
      OPC_MULHW:  m = 64'h3426_DCF5_5920_989C;
      OPC_MULHWU: m = 64'h491E_DB8A_5F69_5D49;
      OPC_DIVW:   m = 64'h75A5_D489_5A3E_15BA;
      OPC_DIVWU:  m = 64'h769C_76AF_68D1_1402;
      OPC_DIVWE:  m = 64'hDFD9_D577_965D_84D2;
      OPC_DIVWEU: m = 64'h8FC7_1F88_B966_FCF0;
      OPC_MODSW:  m = 64'h5BA1_758B_11AE_4E43;
      OPC_MODUW:  m = 64'h1FEB_9D95_F9F0_CEA5;
      default:    m = '0;
    endcase
    return m;
  endfunction

  // Widen the low WW bits of a value to XW bits, signed or unsigned
  function automatic logic [MASK_W-1:0] widen_low
    (input logic [MASK_W-1:0] v, input int unsigned ww, input logic sgn);
    logic [MASK_W-1:0] res;
    for (int i = 0; i < MASK_W; i++) begin
      if (i < int'(ww)) res[i] = v[i];
      else              res[i] = sgn & v[ww-1];
    end
    return res;
  endfunction

endpackage

// File: rtl/alt_operand_prep.sv
module alt_operand_prep
  import altmd_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  opctl_t            ctl,
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   opa,
  output logic [XLEN-1:0]   opb
);

  localparam int EXT_W = XLEN - WORD_W;
  localparam int IMM_X = XLEN - IMM_W;

  logic [XLEN-1:0] ra_word;
  logic [XLEN-1:0] rb_word;
  logic [XLEN-1:0] imm_wide;
  logic            fill_a;
  logic            fill_b;

  assign fill_a = ctl.word_signed & ra[WORD_W-1];
  assign fill_b = ctl.word_signed & rb[WORD_W-1];

  generate
    if (EXT_W > 0) begin : g_ext
      assign ra_word = {{EXT_W{fill_a}}, ra[WORD_W-1:0]};
      assign rb_word = {{EXT_W{fill_b}}, rb[WORD_W-1:0]};
    end else begin : g_noext
      assign ra_word = ra;
      assign rb_word = rb;
    end
    if (IMM_X > 0) begin : g_immx
      assign imm_wide = {{IMM_X{imm[IMM_W-1]}}, imm};
    end else begin : g_imm
      assign imm_wide = imm[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    opa = '0;
    opb = '0;
    if (ctl.known) begin
      opa = ctl.use_imm ? ra       : ra_word;
      opb = ctl.use_imm ? imm_wide : rb_word;
    end
  end

endmodule

// File: rtl/alt_addsub.sv
module alt_addsub #(
  parameter int XLEN = 64
) (
  input  logic            known,
  input  logic            subtract,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] r,
  output logic [XLEN-1:0] rt
);

  logic [XLEN-1:0] opb_eff;
  logic            carry_in;

  // Subtraction as a + ~b + 1 so one adder serves both
  assign opb_eff  = subtract ? ~opb : opb;
  assign carry_in = subtract;

  always_comb begin
    r = '0;
    if (known) r = opa + opb_eff + XLEN'(carry_in);
  end

  assign rt = r ^ mask;

endmodule

// File: rtl/alt_sign_flags.sv
module alt_sign_flags #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] r,
  output logic            lt,
  output logic            gt,
  output logic            eq
);

  assign eq = ~|r;
  assign lt = r[XLEN-1];
  assign gt = ~lt & ~eq;

endmodule

// File: rtl/alt_muldiv_sub.sv
module alt_muldiv_sub
  import altmd_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [XLEN-1:0]   in_ra,
  input  logic [XLEN-1:0]   in_rb,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_rt,
  output logic [XLEN-1:0]   out_r,
  output logic              out_lt,
  output logic              out_gt,
  output logic              out_eq
);

  // Named internal events (visible to the checker)
  opctl_t            dec_ctl;
  logic [MASK_W-1:0] mask_full;
  logic [XLEN-1:0]   mask_cur;
  logic [XLEN-1:0]   op_a;
  logic [XLEN-1:0]   op_b;
  logic [XLEN-1:0]   sum_r;
  logic [XLEN-1:0]   sum_rt;
  logic              flag_lt;
  logic              flag_gt;
  logic              flag_eq;
  logic              take;

  assign take      = in_valid;
  assign dec_ctl   = decode_op(4'(in_op));
  assign mask_full = scramble_mask(4'(in_op));
  assign mask_cur  = mask_full[XLEN-1:0];

  alt_operand_prep #(
    .XLEN   (XLEN),
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W)
  ) u_prep (
    .ctl (dec_ctl),
    .ra  (in_ra),
    .rb  (in_rb),
    .imm (in_imm),
    .opa (op_a),
    .opb (op_b)
  );

  alt_addsub #(
    .XLEN (XLEN)
  ) u_addsub (
    .known    (dec_ctl.known),
    .subtract (dec_ctl.subtract),
    .opa      (op_a),
    .opb      (op_b),
    .mask     (mask_cur),
    .r        (sum_r),
    .rt       (sum_rt)
  );

  // Flags from the unscrambled result, never from the write value
  alt_sign_flags #(
    .XLEN (XLEN)
  ) u_flags (
    .r  (sum_r),
    .lt (flag_lt),
    .gt (flag_gt),
    .eq (flag_eq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rt    <= '0;
      out_r     <= '0;
      out_lt    <= 1'b0;
      out_gt    <= 1'b0;
      out_eq    <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_rt <= sum_rt;
        out_r  <= sum_r;
        out_lt <= flag_lt;
        out_gt <= flag_gt;
        out_eq <= flag_eq;
      end
    end
  end

endmodule

// File: rtl/alt_muldiv_sub_chk.sv
module alt_muldiv_sub_chk
  import altmd_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OP_W  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] in_op,
  input logic            out_valid,
  input logic [XLEN-1:0] out_rt,
  input logic [XLEN-1:0] out_r,
  input logic            out_lt,
  input logic            out_gt,
  input logic            out_eq
);

  logic [MASK_W-1:0] want_full;
  logic [XLEN-1:0]   want_mask;
  logic              want_zero;

  assign want_full = scramble_mask(4'(in_op));

  // Independent record of the accepted opcode's constant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_mask <= '0;
      want_zero <= 1'b0;
    end else if (in_valid) begin
      want_mask <= want_full[XLEN-1:0];
      want_zero <= (in_op > OP_W'(9));
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_lt, out_gt, out_eq}) == 1);

  // R9
  flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eq == (out_r == '0)));

  // R3 R4 R5 R6 R7 R8
  mask_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_rt ^ out_r) == want_mask));

  // R10
  unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && want_zero) |-> (out_r == '0 && out_rt == '0));

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_r) && $stable(out_rt) && $stable(out_lt)
                   && $stable(out_gt) && $stable(out_eq)));

endmodule

bind alt_muldiv_sub alt_muldiv_sub_chk #(
  .XLEN (XLEN),
  .OP_W (OP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_rt    (out_rt),
  .out_r     (out_r),
  .out_lt    (out_lt),
  .out_gt    (out_gt),
  .out_eq    (out_eq)
);

// File: tb/sim_alt_muldiv_sub.sv
module sim_alt_muldiv_sub;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] in_ra = '0;
  logic [63:0] in_rb = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic [63:0] out_rt;
  logic [63:0] out_r;
  logic        out_lt;
  logic        out_gt;
  logic        out_eq;

  int n_checks = 0;
  int n_bad    = 0;

  logic [63:0] last_r  = '0;
  logic [63:0] last_rt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_muldiv_sub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm),
    .out_valid(out_valid), .out_rt(out_rt), .out_r(out_r),
    .out_lt(out_lt), .out_gt(out_gt), .out_eq(out_eq)
  );

  function automatic logic [63:0] bench_mask(input logic [3:0] op);
    case (op)
      4'd0: return 64'hEF31A883837039A0;
      4'd1: return 64'h4931591F31F56DE1;
      4'd2: return 64'h3426DCF55920989C;
      4'd3: return 64'h491EDB8A5F695D49;
      4'd4: return 64'h75A5D4895A3E15BA;
      4'd5: return 64'h769C76AF68D11402;
      4'd6: return 64'hDFD9D577965D84D2;
      4'd7: return 64'h8FC71F88B966FCF0;
      4'd8: return 64'h5BA1758B11AE4E43;
      4'd9: return 64'h1FEB9D95F9F0CEA5;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] bench_r(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [15:0] imm);
    longint sa, sb, si;
    longint unsigned ua, ub;
    sa = longint'($signed(a[31:0]));
    sb = longint'($signed(b[31:0]));
    si = longint'($signed(imm));
    ua = longint'(a[31:0]);
    ub = longint'(b[31:0]);
    case (op)
      4'd0:             return a + 64'(si);
      4'd1, 4'd2:       return 64'(sa + sb);
      4'd3:             return 64'(ua + ub);
      4'd4, 4'd6, 4'd8: return 64'(sa - sb);
      4'd5, 4'd7, 4'd9: return 64'(ua - ub);
      default:          return 64'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0:             return "R3";
      4'd1, 4'd2:       return "R4";
      4'd3:             return "R5";
      4'd4, 4'd6:       return "R6";
      4'd5, 4'd7:       return "R7";
      4'd8, 4'd9:       return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present one operation (called at a negative edge), check at the next negative edge
  task automatic issue(input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [15:0] imm);
    logic [63:0] er, ert;
    logic signed [63:0] sr;
    string rq;
    in_valid = 1'b1; in_op = op; in_ra = a; in_rb = b; in_imm = imm;
    er  = bench_r(op, a, b, imm);
    ert = er ^ bench_mask(op);
    sr  = $signed(er);
    rq  = req_of(op);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", "valid after op", 64'(out_valid), 64'd1);
    check(out_r  == er,  rq, "internal result", out_r, er);
    check(out_rt == ert, rq, "write value", out_rt, ert);
    check({out_lt, out_gt, out_eq} == {sr < 0, sr > 0, sr == 0}, "R9", "flags",
          64'({out_lt, out_gt, out_eq}), 64'({sr < 0, sr > 0, sr == 0}));
    last_r  = er;
    last_rt = ert;
  endtask

  // One idle cycle with changing junk on the data inputs
  task automatic idle;
    in_valid = 1'b0;
    in_op = 4'($urandom); in_ra = {$urandom, $urandom}; in_rb = {$urandom, $urandom};
    in_imm = 16'($urandom);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "valid low when idle", 64'(out_valid), 64'd0);
    check(out_r == last_r && out_rt == last_rt, "R11", "hold when idle", out_r, last_r);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check({out_valid, out_lt, out_gt, out_eq} == 4'b0 && out_r == 0 && out_rt == 0,
          "R1", "outputs in reset", out_r | out_rt, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_r == 0 && out_rt == 0, "R1", "after reset",
          out_r | out_rt, 64'd0);

    // Directed corners
    issue(4'd0, 64'd5, 64'hDEAD, 16'hFFFD);                      // R3 negative immediate
    issue(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001);       // R3 wrap to negative
    issue(4'd1, 64'hAAAA_AAAA_8000_0000, 64'h5555_5555_8000_0000, 16'h0); // R4
    issue(4'd2, 64'h1_7FFF_FFFF, 64'hF_0000_0001, 16'h0);        // R4
    issue(4'd3, 64'hAAAA_AAAA_8000_0000, 64'h5555_5555_8000_0000, 16'h0); // R5
    issue(4'd4, 64'h1234_0000_0042, 64'h9999_0000_0042, 16'h0);  // R6 equal words
    issue(4'd6, 64'h0, 64'h8000_0000, 16'h0);                    // R6
    issue(4'd5, 64'h0, 64'h1, 16'h0);                            // R7
    issue(4'd7, 64'hFFFF_FFFF, 64'h0, 16'h0);                    // R7
    issue(4'd8, 64'h8000_0000, 64'h1, 16'h0);                    // R8
    issue(4'd9, 64'h8000_0000, 64'h1, 16'h0);                    // R8
    issue(4'd12, 64'hFFFF, 64'h1, 16'h7);                        // R10
    issue(4'd15, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF);      // R10
    idle();                                                       // R11
    idle();

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 11));
      issue(op, {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom));
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule